// File: doc/BRIEF.md
# Data Operand Address Resolver

This block sits beside the decode stage of a small 8-bit accumulator core. It works out where the source or destination operand of the current instruction lives in internal data memory. The core pulses `start` and presents the opcode byte, the byte that follows it, and the two register-bank select bits. The block sorts the operand into one of five classes:

- a banked working register
- a directly addressed location
- a pointer-indirect location
- an immediate constant
- an implied fixed register

It then reports the resolved address, or the constant, or the fixed register, and pulses `done`.

Most classes resolve in one cycle. A pointer-indirect operand first reads the pointer register's content through a synchronous single-port RAM read interface. That byte is then taken as the final operand address. Special-function-register side effects, instruction fetch and execution belong to other blocks.

The class depends only on the low nibble of the opcode. The high nibble is the operation and is ignored here.

Top module: `opres_top`

## Requirements
- R1: After a synchronous reset, `done`, `busy` and `ramRdEn` are low and `opMode` reads 0.
- R2: The opcode low nibble selects the class, reported on `opMode`:
  - 8h..Fh is register (code 1).
  - 5h is direct (code 2).
  - 6h or 7h is indirect (code 3).
  - 3h or 4h is immediate (code 4).
  - 0h, 1h, 2h are implied (code 5).
- R3: A register operand resolves to `opAddr` = bank*8 + opcode[2:0], with `done` high in the cycle after the start edge and no RAM read.
- R4: A direct operand resolves to `opAddr` = the operand byte, with one-cycle latency. Register 7 in bank 0 and direct address 07h give the same address.
- R5: `sfrSpace` is high exactly when the class is direct and the operand byte is 80h or above.
- R6: An immediate operand sets `immValue` to the operand byte, with `opAddr` 0 and no RAM read. For every other class `immValue` is 0.
- R7: An implied operand reports `impliedReg`:
  - accumulator = 1 for low nibble 0h;
  - B register = 2 for 1h;
  - data pointer = 3 for 2h.

  `opAddr` is 0 and there is no RAM read. For other classes `impliedReg` is 0.
- R8: An indirect operand asserts `ramRdEn` for exactly one cycle, the cycle after the start edge, at `ramRdAddr` = bank*8 + opcode[0]. Read data is valid the following cycle. `opAddr` takes that byte, and `done` rises one cycle after the data is valid.
- R9: For an indirect operand, `upperRam` is high exactly when the fetched address is 80h or above, and `sfrSpace` stays low.
- R10: A `start` pulse while `busy` is high is ignored. The running resolution completes with its own results and no extra `done`.
- R11: `busy` is high from the cycle after an indirect start until `done` rises, and `done` is never high while `busy` is high.
- R12: A synchronous reset during an indirect sequence returns the block to idle, with `busy`, `done` and `ramRdEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resolution with the presented opcode and operand |
| opcode | input | 8 | Instruction opcode byte |
| operandByte | input | 8 | Byte following the opcode |
| bankSel | input | 2 | Active register bank |
| ramRdData | input | 8 | RAM read data, valid the cycle after a read strobe |
| ramRdEn | output | 1 | RAM read strobe for the pointer fetch |
| ramRdAddr | output | 8 | RAM read address of the pointer register |
| busy | output | 1 | Indirect sequence in progress |
| done | output | 1 | Result outputs valid this cycle |
| opMode | output | 3 | Operand class code |
| opAddr | output | 8 | Resolved internal RAM address |
| immValue | output | 8 | Immediate constant |
| impliedReg | output | 2 | Implied register code |
| sfrSpace | output | 1 | Direct address lies in the special-register range |
| upperRam | output | 1 | Indirect address lies in upper internal RAM |

## Verification
The bench builds the block with its default parameters: an 8-bit address, four register banks of eight registers, and a synchronous RAM model with one-cycle read latency. That size reaches the top bank (register addresses up to 1Fh) and both sides of the 7Fh/80h split. The split is exercised for direct addresses and for fetched pointer values. Pointer cells hold values both above and below 80h, so the upper-RAM flag is seen in both states. Timing is checked cycle by cycle, including the single read strobe, a start pulse arriving mid-sequence, and a reset arriving mid-sequence.

// File: rtl/opres_pkg.sv
package opres_pkg;

  typedef enum logic [2:0] {
    MODE_NONE     = 3'd0,
    MODE_REG      = 3'd1,
    MODE_DIRECT   = 3'd2,
    MODE_INDIRECT = 3'd3,
    MODE_IMM      = 3'd4,
    MODE_IMPLIED  = 3'd5
  } opModeE;

  typedef enum logic [1:0] {
    IMP_NONE = 2'd0,
    IMP_ACC  = 2'd1,
    IMP_BREG = 2'd2,
    IMP_DPTR = 2'd3
  } impRegE;

  typedef struct packed {
    logic capture;
    logic ptrRead;
    logic ptrLoad;
    logic finish;
  } ctrlStrobeT;

  // Operand class from the opcode low nibble; the high nibble is the operation.
  function automatic opModeE classifyOpcode(input logic [7:0] opc);
    opModeE m;
    if (opc[3]) begin
      m = MODE_REG;
    end else begin
      case (opc[2:0])
        3'd0, 3'd1, 3'd2: m = MODE_IMPLIED;
        3'd3, 3'd4:       m = MODE_IMM;
        3'd5:             m = MODE_DIRECT;
        default:          m = MODE_INDIRECT;
      endcase
    end
    return m;
  endfunction

  function automatic impRegE impliedOf(input logic [7:0] opc);
    impRegE r;
    case (opc[1:0])
      2'd0:    r = IMP_ACC;
      2'd1:    r = IMP_BREG;
      default: r = IMP_DPTR;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/opres_ctrl.sv
module opres_ctrl
  import opres_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       startIndirect,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {
    S_IDLE     = 2'd0,
    S_PTR_RD   = 2'd1,
    S_PTR_WAIT = 2'd2
  } stateE;

  stateE state;
  stateE nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          if (startIndirect) begin
            nextState = S_PTR_RD;
          end else begin
            strobe.finish = 1'b1;
          end
        end
      end
      S_PTR_RD: begin
        strobe.ptrRead = 1'b1;
        nextState      = S_PTR_WAIT;
      end
      S_PTR_WAIT: begin
        strobe.ptrLoad = 1'b1;
        strobe.finish  = 1'b1;
        nextState      = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobe.finish;
    end
  end

  assign busy = (state != S_IDLE);

  // R11: completion never overlaps a running sequence
  assert_busy_excludes_done_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  // R8: the pointer read is followed by one data cycle, then done
  assert_read_then_done_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.ptrRead |=> (!done ##1 done));

  // R10: a start seen while busy never recaptures
  assert_no_capture_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !strobe.capture);

endmodule

// File: rtl/opres_dp.sv
module opres_dp
  import opres_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_N  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobeT        strobe,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] operandByte,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] ramRdData,
  output logic              startIndirect,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr,
  output logic [2:0]        opMode,
  output logic [ADDR_W-1:0] opAddr,
  output logic [ADDR_W-1:0] immValue,
  output logic [1:0]        impliedReg,
  output logic              sfrSpace,
  output logic              upperRam
);

  localparam int IDX_W     = $clog2(REG_N);
  localparam int REG_SPAN  = REG_N << BANK_W;

  opModeE            inMode;
  logic [ADDR_W-1:0] regAddr;
  logic [ADDR_W-1:0] ptrSlot;
  logic [ADDR_W-1:0] ptrAddrQ;
  opModeE            modeQ;

  assign inMode        = classifyOpcode(opcode);
  assign startIndirect = (inMode == MODE_INDIRECT);

  // Banked register slot: bank*REG_N + index.
  assign regAddr = ADDR_W'({bankSel, opcode[IDX_W-1:0]});

  // Pointer register: only index 0 or 1 of the active bank.
  generate
    if (IDX_W > 1) begin : g_ptrWide
      assign ptrSlot = ADDR_W'({bankSel, {(IDX_W-1){1'b0}}, opcode[0]});
    end else begin : g_ptrNarrow
      assign ptrSlot = ADDR_W'({bankSel, opcode[0]});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ      <= MODE_NONE;
      ptrAddrQ   <= '0;
      opAddr     <= '0;
      immValue   <= '0;
      impliedReg <= IMP_NONE;
      sfrSpace   <= 1'b0;
      upperRam   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        modeQ      <= inMode;
        ptrAddrQ   <= ptrSlot;
        upperRam   <= 1'b0;
        immValue   <= (inMode == MODE_IMM) ? operandByte : '0;
        impliedReg <= (inMode == MODE_IMPLIED) ? impliedOf(opcode) : IMP_NONE;
        sfrSpace   <= (inMode == MODE_DIRECT) && operandByte[ADDR_W-1];
        case (inMode)
          MODE_REG:    opAddr <= regAddr;
          MODE_DIRECT: opAddr <= operandByte;
          default:     opAddr <= '0;
        endcase
      end
      if (strobe.ptrLoad) begin
        opAddr   <= ramRdData;
        upperRam <= ramRdData[ADDR_W-1];
      end
    end
  end

  assign opMode    = modeQ;
  assign ramRdEn   = strobe.ptrRead;
  assign ramRdAddr = ptrAddrQ;

  // R9: fetched addresses are never tagged as special-register space
  assert_sfr_not_indirect_R9: assert property (@(posedge clk) disable iff (rst)
    (opMode == MODE_INDIRECT) |-> !sfrSpace);

  // R3: register operands stay within the banked register window
  assert_reg_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    (opMode == MODE_REG) |-> (32'(opAddr) < REG_SPAN));

  // R6: immediate operands carry no address and trigger no read
  assert_imm_no_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (opMode == MODE_IMM) |-> (opAddr == '0 && !ramRdEn));

  // R8: the read strobe lasts exactly one cycle
  assert_read_single_R8: assert property (@(posedge clk) disable iff (rst)
    ramRdEn |=> !ramRdEn);

endmodule

// File: rtl/opres_top.sv
module opres_top
  import opres_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_N  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] operandByte,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] ramRdData,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr,
  output logic              busy,
  output logic              done,
  output logic [2:0]        opMode,
  output logic [ADDR_W-1:0] opAddr,
  output logic [ADDR_W-1:0] immValue,
  output logic [1:0]        impliedReg,
  output logic              sfrSpace,
  output logic              upperRam
);

  ctrlStrobeT strobe;
  logic       startIndirect;

  opres_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .startIndirect (startIndirect),
    .strobe        (strobe),
    .busy          (busy),
    .done          (done)
  );

  opres_dp #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .REG_N  (REG_N)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .opcode        (opcode),
    .operandByte   (operandByte),
    .bankSel       (bankSel),
    .ramRdData     (ramRdData),
    .startIndirect (startIndirect),
    .ramRdEn       (ramRdEn),
    .ramRdAddr     (ramRdAddr),
    .opMode        (opMode),
    .opAddr        (opAddr),
    .immValue      (immValue),
    .impliedReg    (impliedReg),
    .sfrSpace      (sfrSpace),
    .upperRam      (upperRam)
  );

  // R10: a start during a sequence leaves the captured class untouched
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(opMode) && $stable(immValue)));

endmodule

// File: tb/opres_top_test.sv
module opres_top_test;

  typedef struct packed {
    logic [7:0] opc;
    logic [7:0] opnd;
    logic [1:0] bank;
    logic [2:0] mode;
    logic [7:0] addr;
    logic [7:0] imm;
    logic [1:0] impl;
    logic       sfr;
    logic       up;
  } vecT;

  localparam int NVEC = 18;
  // Pointer cells hold addr ^ A5h, except 10h -> 7Fh and 19h -> 3Ch.
  localparam vecT VECS [NVEC] = '{
    '{8'h2F, 8'h00, 2'd0, 3'd1, 8'h07, 8'h00, 2'd0, 1'b0, 1'b0},
    '{8'hE5, 8'h07, 2'd0, 3'd2, 8'h07, 8'h00, 2'd0, 1'b0, 1'b0},
    '{8'h38, 8'h55, 2'd1, 3'd1, 8'h08, 8'h00, 2'd0, 1'b0, 1'b0},
    '{8'h1D, 8'h00, 2'd3, 3'd1, 8'h1D, 8'h00, 2'd0, 1'b0, 1'b0},
    '{8'h85, 8'h90, 2'd1, 3'd2, 8'h90, 8'h00, 2'd0, 1'b1, 1'b0},
    '{8'h05, 8'h7F, 2'd2, 3'd2, 8'h7F, 8'h00, 2'd0, 1'b0, 1'b0},
    '{8'h05, 8'h80, 2'd0, 3'd2, 8'h80, 8'h00, 2'd0, 1'b1, 1'b0},
    '{8'h74, 8'h3C, 2'd0, 3'd4, 8'h00, 8'h3C, 2'd0, 1'b0, 1'b0},
    '{8'h93, 8'hFF, 2'd2, 3'd4, 8'h00, 8'hFF, 2'd0, 1'b0, 1'b0},
    '{8'hA0, 8'h12, 2'd0, 3'd5, 8'h00, 8'h00, 2'd1, 1'b0, 1'b0},
    '{8'hA1, 8'h34, 2'd1, 3'd5, 8'h00, 8'h00, 2'd2, 1'b0, 1'b0},
    '{8'hA2, 8'h56, 2'd3, 3'd5, 8'h00, 8'h00, 2'd3, 1'b0, 1'b0},
    '{8'hE6, 8'h00, 2'd0, 3'd3, 8'hA5, 8'h00, 2'd0, 1'b0, 1'b1},
    '{8'hE7, 8'h00, 2'd0, 3'd3, 8'hA4, 8'h00, 2'd0, 1'b0, 1'b1},
    '{8'h07, 8'h99, 2'd2, 3'd3, 8'hB4, 8'h00, 2'd0, 1'b0, 1'b1},
    '{8'h06, 8'h00, 2'd2, 3'd3, 8'h7F, 8'h00, 2'd0, 1'b0, 1'b0},
    '{8'h17, 8'h00, 2'd3, 3'd3, 8'h3C, 8'h00, 2'd0, 1'b0, 1'b0},
    '{8'h06, 8'h00, 2'd1, 3'd3, 8'hAD, 8'h00, 2'd0, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] opcode = '0;
  logic [7:0] operandByte = '0;
  logic [1:0] bankSel = '0;
  logic [7:0] ramRdData;
  logic       ramRdEn;
  logic [7:0] ramRdAddr;
  logic       busy, done, sfrSpace, upperRam;
  logic [2:0] opMode;
  logic [7:0] opAddr, immValue;
  logic [1:0] impliedReg;

  logic [7:0] mem [256];
  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (ramRdEn) ramRdData <= mem[ramRdAddr];
  end

  opres_top uut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .operandByte(operandByte), .bankSel(bankSel), .ramRdData(ramRdData),
    .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr), .busy(busy), .done(done),
    .opMode(opMode), .opAddr(opAddr), .immValue(immValue),
    .impliedReg(impliedReg), .sfrSpace(sfrSpace), .upperRam(upperRam)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkResult(input vecT v);
    chk("R2 class code", 32'(opMode), 32'(v.mode));
    chk(v.mode == 3'd3 ? "R8 fetched address" : "R3/R4 operand address",
        32'(opAddr), 32'(v.addr));
    chk("R6 immediate value", 32'(immValue), 32'(v.imm));
    chk("R7 implied register", 32'(impliedReg), 32'(v.impl));
    chk("R5 special-register flag", 32'(sfrSpace), 32'(v.sfr));
    chk("R9 upper RAM flag", 32'(upperRam), 32'(v.up));
  endtask

  task automatic runVec(input vecT v);
    @(negedge clk);
    opcode = v.opc; operandByte = v.opnd; bankSel = v.bank; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v.mode == 3'd3) begin
      chk("R8 read strobe", 32'(ramRdEn), 32'd1);
      chk("R8 pointer address", 32'(ramRdAddr), 32'(v.bank) * 8 + 32'(v.opc[0]));
      chk("R11 busy during fetch", 32'(busy), 32'd1);
      @(negedge clk);
      chk("R8 read single cycle", 32'(ramRdEn), 32'd0);
      chk("R11 done low while busy", 32'(done), 32'd0);
      @(negedge clk);
    end else begin
      chk("R3 no RAM read for non-indirect", 32'(ramRdEn), 32'd0);
    end
    chk("R3/R8 done timing", 32'(done), 32'd1);
    checkResult(v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'(a) ^ 8'hA5;
    mem[8'h10] = 8'h7F;
    mem[8'h19] = 8'h3C;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset done", 32'(done), 32'd0);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset read strobe", 32'(ramRdEn), 32'd0);
    chk("R1 reset class", 32'(opMode), 32'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R4: register 7 of bank 0 and direct 07h coincide (vectors 0 and 1)
    chk("R4 register/direct alias", 32'(VECS[0].addr), 32'(VECS[1].addr));

    // R10: start while busy is ignored
    @(negedge clk);
    opcode = 8'hE6; bankSel = 2'd0; start = 1'b1;
    @(negedge clk);
    opcode = 8'h74; operandByte = 8'h66; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 no done from ignored start", 32'(done), 32'd0);
    @(negedge clk);
    chk("R10 original sequence completes", 32'(done), 32'd1);
    chk("R10 class kept", 32'(opMode), 32'd3);
    chk("R10 address kept", 32'(opAddr), 32'hA5);
    chk("R10 immediate untouched", 32'(immValue), 32'd0);
    @(negedge clk);
    chk("R10 no extra done", 32'(done), 32'd0);
    chk("R11 idle after done", 32'(busy), 32'd0);

    // R12: reset during an indirect sequence
    @(negedge clk);
    opcode = 8'h07; bankSel = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 fetch begun", 32'(ramRdEn), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 busy cleared", 32'(busy), 32'd0);
    chk("R12 done cleared", 32'(done), 32'd0);
    chk("R12 read strobe cleared", 32'(ramRdEn), 32'd0);
    @(negedge clk);
    chk("R12 no late done", 32'(done), 32'd0);
    runVec(VECS[16]);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule